// File: doc/BRIEF.md
# Bus Register Interface with Interrupts

This block is a byte-wide slave on a microprocessor bus. It connects the bus to a serial link engine. The processor sees four registers, chosen by two select lines and a read/not-write line, and every access is framed by an active-low chip select:

- a received-byte register;
- a transmit-byte register;
- a status register for the receive direction;
- a status register for the transmit direction.

Each status register holds a ready flag and an interrupt enable. Each interrupt line is the AND of the two.

The link engine talks to this block through single-cycle strobes:

- **Receive side.** `rx_valid` delivers a byte. The block answers with `rx_ack` when the processor has consumed that byte by reading it.
- **Transmit side.** The block issues `tx_req` with a byte. The engine reports `tx_done` once the packet has left and the far end has acknowledged it.

The bidirectional data bus is split into an input, an output and an output enable. The pad ring joins them.

Chip select is brought into the clock domain through a parameterised synchroniser. The select lines and read/not-write are captured when the synchronised chip select falls. Write data is captured, and side effects happen, when it rises. Reset is asserted asynchronously and released synchronously inside the block.

Top module: `link_bus_regs`

## Requirements
- R1: Register select and read/not-write are captured at the falling edge of chip select. Changes to them while chip select stays low have no effect on the access. The access key is {sel[1], sel[0], rd_nwr}:
  - 001 reads received data;
  - 010 writes transmit data;
  - 101 / 100 read / write receive status;
  - 111 / 110 read / write transmit status.
- R2: Write data is taken when chip select rises. The value on `bus_din` at that point is the one used, whatever was driven earlier in the access.
- R3: `bus_oe` is high only while a read access is in progress. It is low during writes and when the block is not selected. `bus_dout` is zero whenever `bus_oe` is low.
- R4: In both status registers, bit 0 reads the flag and bit 1 reads the interrupt enable. Bits 7..2 read zero. A status write loads only the enable from bit 1 and never changes the flag.
- R5: `rx_irq` = data-present AND receive enable, and `tx_irq` = output-ready AND transmit enable. Clearing an enable drops its interrupt. Setting it again re-raises the interrupt while the flag is still set.
- R6: An `rx_valid` strobe stores `rx_byte` and sets data-present. A completed read of received data (key 001) does three things:
  - clears data-present, and with it `rx_irq`;
  - returns the stored byte;
  - pulses `rx_ack` exactly once, provided data was present. A read with nothing present produces no `rx_ack`.
- R7: A transmit-data write (key 010) made while output-ready is high does three things:
  - clears output-ready;
  - pulses `tx_req` once;
  - presents the written byte on `tx_byte`.

  Output-ready returns high only on a `tx_done` strobe.
- R8: After reset:
  - receive status reads 0x00 and transmit status reads 0x01;
  - both interrupts are low;
  - `bus_oe` is low;
  - `tx_overrun` is low.
- R9: A write to key 000 and a read of key 011 change no state. The read returns zero with `bus_oe` high.
- R10: A transmit-data write made while output-ready is low is dropped: no `tx_req`, and `tx_byte` is unchanged. It sets `tx_overrun`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select (asynchronous to clk) |
| reg_sel | input | 2 | Register select lines |
| rd_nwr | input | 1 | High for read, low for write |
| bus_din | input | DW | Data bus, inbound half |
| bus_dout | output | DW | Data bus, outbound half |
| bus_oe | output | 1 | Enable for the outbound bus drivers |
| rx_irq | output | 1 | Received data available interrupt |
| tx_irq | output | 1 | Transmitter free interrupt |
| rx_valid | input | 1 | Link engine delivers a received byte |
| rx_byte | input | DW | Received byte |
| rx_ack | output | 1 | Received byte consumed; engine may send acknowledge |
| tx_req | output | 1 | Start sending `tx_byte` |
| tx_byte | output | DW | Byte to send |
| tx_done | input | 1 | Packet sent and remote acknowledge received |
| tx_overrun | output | 1 | Sticky: transmit write arrived while not ready |

## Verification
The bench builds the block with its defaults: an eight-bit bus and two chip-select synchroniser stages. Each access therefore goes through the full detection delay on both chip-select edges. The bench holds chip select low long enough to move the select and data lines in the middle of an access, which shows that only the values at the capture points count. The same delay gives room to watch the interrupt lines and the single-cycle link strobes between accesses. That includes a data read with nothing present and a transmit write while busy.

// File: rtl/lbr_pkg.sv
package lbr_pkg;

  // Access key {sel[1], sel[0], rd_nwr}
  typedef enum logic [2:0] {
    KEY_RXD_WR = 3'b000,
    KEY_RXD_RD = 3'b001,
    KEY_TXD_WR = 3'b010,
    KEY_TXD_RD = 3'b011,
    KEY_RXS_WR = 3'b100,
    KEY_RXS_RD = 3'b101,
    KEY_TXS_WR = 3'b110,
    KEY_TXS_RD = 3'b111
  } key_e;

  localparam int FLAG_BIT = 0;
  localparam int IE_BIT   = 1;

  // One-cycle completion strobes produced at the end of an access
  typedef struct packed {
    logic rxd_rd;
    logic rxs_wr;
    logic txd_wr;
    logic txs_wr;
  } acc_t;

endpackage

// File: rtl/lbr_rst_sync.sv
module lbr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/lbr_cpu_port.sv
module lbr_cpu_port
  import lbr_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic [1:0]    reg_sel,
  input  logic          rd_nwr,
  input  logic [DW-1:0] bus_din,
  output key_e          key_o,
  output logic          rd_oe_o,
  output acc_t          acc_o,
  output logic [DW-1:0] wdata_o
);
  logic cs_s;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign cs_s = cs_n;
    end else begin : g_sync
      logic [SYNC_STAGES:0] chain;
      assign chain[0] = cs_n;
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i+1] <= 1'b1;
          else        chain[i+1] <= chain[i];
        end
      end
      assign cs_s = chain[SYNC_STAGES];
    end
  endgenerate

  logic          cs_q;
  logic          active_q, active_d;
  key_e          key_q, key_d;
  acc_t          acc_q, acc_d;
  logic [DW-1:0] wdata_q, wdata_d;
  logic          fall, rise;

  assign fall = cs_q & ~cs_s;
  assign rise = ~cs_q & cs_s;

  always_comb begin
    key_d    = key_q;
    active_d = active_q;
    wdata_d  = wdata_q;
    acc_d    = '0;
    if (fall) begin
      key_d    = key_e'({reg_sel, rd_nwr});
      active_d = 1'b1;
    end
    if (rise) begin
      active_d = 1'b0;
      wdata_d  = bus_din;
      if (active_q) begin
        case (key_q)
          KEY_RXD_RD: acc_d.rxd_rd = 1'b1;
          KEY_RXS_WR: acc_d.rxs_wr = 1'b1;
          KEY_TXD_WR: acc_d.txd_wr = 1'b1;
          KEY_TXS_WR: acc_d.txs_wr = 1'b1;
          default:    ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q     <= 1'b1;
      active_q <= 1'b0;
      key_q    <= KEY_RXD_WR;
      acc_q    <= '0;
      wdata_q  <= '0;
    end else begin
      cs_q     <= cs_s;
      active_q <= active_d;
      key_q    <= key_d;
      acc_q    <= acc_d;
      wdata_q  <= wdata_d;
    end
  end

  assign key_o   = key_q;
  assign rd_oe_o = active_q & key_q[0];
  assign acc_o   = acc_q;
  assign wdata_o = wdata_q;

  // R1
  key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && $past(active_q)) |-> $stable(key_q));
  // R1
  acc_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|acc_q) |-> (!active_q && cs_q));
  // R3
  oe_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe_o |-> !cs_q);
endmodule

// File: rtl/lbr_rx_chan.sv
module lbr_rx_chan
  import lbr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  acc_t          acc,
  input  logic [DW-1:0] wdata,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  output logic [DW-1:0] data_o,
  output logic [DW-1:0] status_o,
  output logic          irq_o,
  output logic          ack_o
);
  logic          present_q, present_d;
  logic          ie_q, ie_d;
  logic [DW-1:0] data_q, data_d;
  logic          ack_q, ack_d;

  always_comb begin
    present_d = present_q;
    ie_d      = ie_q;
    data_d    = data_q;
    ack_d     = 1'b0;
    if (acc.rxs_wr) ie_d = wdata[IE_BIT];
    if (acc.rxd_rd) begin
      present_d = 1'b0;
      ack_d     = present_q;
    end
    if (rx_valid) begin
      present_d = 1'b1;
      data_d    = rx_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      present_q <= 1'b0;
      ie_q      <= 1'b0;
      data_q    <= '0;
      ack_q     <= 1'b0;
    end else begin
      present_q <= present_d;
      ie_q      <= ie_d;
      data_q    <= data_d;
      ack_q     <= ack_d;
    end
  end

  always_comb begin
    status_o           = '0;
    status_o[FLAG_BIT] = present_q;
    status_o[IE_BIT]   = ie_q;
  end

  assign data_o = data_q;
  assign irq_o  = present_q & ie_q;
  assign ack_o  = ack_q;

  // R6
  rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> present_q);
  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> (!present_q || $past(rx_valid)));
  // R4
  rx_flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.rxs_wr && !acc.rxd_rd && !rx_valid) |=> (present_q == $past(present_q)));
endmodule

// File: rtl/lbr_tx_chan.sv
module lbr_tx_chan
  import lbr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  acc_t          acc,
  input  logic [DW-1:0] wdata,
  input  logic          tx_done,
  output logic [DW-1:0] status_o,
  output logic          irq_o,
  output logic          req_o,
  output logic [DW-1:0] byte_o,
  output logic          ovr_o
);
  logic          ready_q, ready_d;
  logic          ie_q, ie_d;
  logic [DW-1:0] byte_q, byte_d;
  logic          req_q, req_d;
  logic          ovr_q, ovr_d;

  always_comb begin
    ready_d = ready_q;
    ie_d    = ie_q;
    byte_d  = byte_q;
    req_d   = 1'b0;
    ovr_d   = ovr_q;
    if (acc.txs_wr) ie_d = wdata[IE_BIT];
    if (acc.txd_wr) begin
      if (ready_q) begin
        ready_d = 1'b0;
        byte_d  = wdata;
        req_d   = 1'b1;
      end else begin
        ovr_d = 1'b1;
      end
    end
    if (tx_done) ready_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b1;
      ie_q    <= 1'b0;
      byte_q  <= '0;
      req_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      ready_q <= ready_d;
      ie_q    <= ie_d;
      byte_q  <= byte_d;
      req_q   <= req_d;
      ovr_q   <= ovr_d;
    end
  end

  always_comb begin
    status_o           = '0;
    status_o[FLAG_BIT] = ready_q;
    status_o[IE_BIT]   = ie_q;
  end

  assign irq_o  = ready_q & ie_q;
  assign req_o  = req_q;
  assign byte_o = byte_q;
  assign ovr_o  = ovr_q;

  // R7
  ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_q) |-> req_q);
  // R7
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> $past(tx_done));
  // R10
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> ovr_q);
  // R10
  ovr_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> (!req_q && $stable(byte_q)));
endmodule

// File: rtl/link_bus_regs.sv
module link_bus_regs
  import lbr_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic [1:0]    reg_sel,
  input  logic          rd_nwr,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  output logic          rx_irq,
  output logic          tx_irq,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  output logic          rx_ack,
  output logic          tx_req,
  output logic [DW-1:0] tx_byte,
  input  logic          tx_done,
  output logic          tx_overrun
);
  logic          rst_i_n;
  key_e          key;
  logic          rd_oe;
  acc_t          acc;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rx_data, rx_status, tx_status;
  logic [DW-1:0] rd_mux;

  lbr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  lbr_cpu_port #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_port (
    .clk(clk), .rst_n(rst_i_n), .cs_n(cs_n), .reg_sel(reg_sel),
    .rd_nwr(rd_nwr), .bus_din(bus_din), .key_o(key), .rd_oe_o(rd_oe),
    .acc_o(acc), .wdata_o(wdata)
  );

  lbr_rx_chan #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_i_n), .acc(acc), .wdata(wdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .data_o(rx_data),
    .status_o(rx_status), .irq_o(rx_irq), .ack_o(rx_ack)
  );

  lbr_tx_chan #(.DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_i_n), .acc(acc), .wdata(wdata),
    .tx_done(tx_done), .status_o(tx_status), .irq_o(tx_irq),
    .req_o(tx_req), .byte_o(tx_byte), .ovr_o(tx_overrun)
  );

  always_comb begin
    case (key)
      KEY_RXD_RD: rd_mux = rx_data;
      KEY_RXS_RD: rd_mux = rx_status;
      KEY_TXS_RD: rd_mux = tx_status;
      default:    rd_mux = '0;
    endcase
  end

  assign bus_oe   = rd_oe;
  assign bus_dout = rd_oe ? rd_mux : '0;

  // R3
  dout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !bus_oe |-> (bus_dout == '0));
endmodule

// File: tb/link_bus_regs_bench.sv
`timescale 1ns/1ps
module link_bus_regs_bench;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cs_n;
  logic [1:0]    reg_sel;
  logic          rd_nwr;
  logic [DW-1:0] bus_din;
  logic [DW-1:0] bus_dout;
  logic          bus_oe;
  logic          rx_irq, tx_irq;
  logic          rx_valid;
  logic [DW-1:0] rx_byte;
  logic          rx_ack;
  logic          tx_req;
  logic [DW-1:0] tx_byte;
  logic          tx_done;
  logic          tx_overrun;

  always #2 clk = ~clk;

  link_bus_regs #(.DW(DW), .SYNC_STAGES(2)) u_link_bus_regs (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .reg_sel(reg_sel), .rd_nwr(rd_nwr),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .rx_irq(rx_irq), .tx_irq(tx_irq), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_ack(rx_ack), .tx_req(tx_req), .tx_byte(tx_byte), .tx_done(tx_done),
    .tx_overrun(tx_overrun)
  );

  int tests = 0;
  int fails = 0;
  int ack_cnt = 0;
  int req_cnt = 0;
  bit finished = 0;

  always @(posedge clk) begin
    if (rx_ack) ack_cnt++;
    if (tx_req) req_cnt++;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One bus access; select/data move to *_mid while chip select is still low.
  task automatic access(input logic [1:0] s, input logic r, input logic [7:0] d,
                        input logic [1:0] s_mid, input logic [7:0] d_mid,
                        output logic [7:0] rd, output logic oe_mid);
    @(negedge clk);
    reg_sel = s; rd_nwr = r; bus_din = d; cs_n = 1'b0;
    repeat (5) @(negedge clk);
    rd = bus_dout; oe_mid = bus_oe;
    reg_sel = s_mid; bus_din = d_mid;
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic acc(input logic [1:0] s, input logic r, input logic [7:0] d,
                     output logic [7:0] rd);
    logic oe;
    access(s, r, d, s, d, rd, oe);
  endtask

  task automatic rx_pulse(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic done_pulse();
    @(negedge clk);
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Vector: [25:24] op (0 access, 1 rx byte, 2 tx done), [23:22] sel,
  // [21] rd_nwr, [20:13] data, [12:5] expected read, [4] check, [3:0] requirement
  localparam int NV = 21;
  localparam logic [25:0] VEC [0:NV-1] = '{
    {2'd0, 2'd2, 1'b1, 8'h00, 8'h00, 1'b1, 4'd8},  // R8 rx status after reset
    {2'd0, 2'd3, 1'b1, 8'h00, 8'h01, 1'b1, 4'd8},  // R8 tx status after reset
    {2'd1, 2'd0, 1'b0, 8'hA5, 8'h00, 1'b0, 4'd6},  // R6 byte arrives
    {2'd0, 2'd2, 1'b1, 8'h00, 8'h01, 1'b1, 4'd6},  // R6 present set
    {2'd0, 2'd0, 1'b1, 8'h00, 8'hA5, 1'b1, 4'd6},  // R6 read byte
    {2'd0, 2'd2, 1'b1, 8'h00, 8'h00, 1'b1, 4'd6},  // R6 present cleared
    {2'd0, 2'd2, 1'b0, 8'h02, 8'h00, 1'b0, 4'd4},  // R4 enable rx irq
    {2'd0, 2'd2, 1'b1, 8'h00, 8'h02, 1'b1, 4'd4},  // R4 enable bit 1
    {2'd0, 2'd2, 1'b0, 8'h01, 8'h00, 1'b0, 4'd4},  // R4 try to set flag
    {2'd0, 2'd2, 1'b1, 8'h00, 8'h00, 1'b1, 4'd4},  // R4 flag untouched
    {2'd0, 2'd3, 1'b0, 8'h02, 8'h00, 1'b0, 4'd4},  // R4 tx enable, flag bit 0
    {2'd0, 2'd3, 1'b1, 8'h00, 8'h03, 1'b1, 4'd4},  // R4 tx status layout
    {2'd0, 2'd1, 1'b0, 8'h3C, 8'h00, 1'b0, 4'd7},  // R7 send byte
    {2'd0, 2'd3, 1'b1, 8'h00, 8'h02, 1'b1, 4'd7},  // R7 not ready
    {2'd2, 2'd0, 1'b0, 8'h00, 8'h00, 1'b0, 4'd7},  // R7 remote ack
    {2'd0, 2'd3, 1'b1, 8'h00, 8'h03, 1'b1, 4'd7},  // R7 ready again
    {2'd0, 2'd1, 1'b1, 8'h00, 8'h00, 1'b1, 4'd9},  // R9 tx data read is zero
    {2'd0, 2'd0, 1'b0, 8'h77, 8'h00, 1'b0, 4'd9},  // R9 write to rx data
    {2'd0, 2'd2, 1'b1, 8'h00, 8'h00, 1'b1, 4'd9},  // R9 no state change
    {2'd1, 2'd0, 1'b0, 8'h5A, 8'h00, 1'b0, 4'd6},  // R6 second byte
    {2'd0, 2'd0, 1'b1, 8'h00, 8'h5A, 1'b1, 4'd6}   // R6 read second byte
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic       oe;
    int         a0, r0;
    rst_n = 1'b0; cs_n = 1'b1; reg_sel = 2'd0; rd_nwr = 1'b1; bus_din = '0;
    rx_valid = 1'b0; rx_byte = '0; tx_done = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R8 reset state at the ports
    chk("R8", "rx_irq", rx_irq, 0);
    chk("R8", "tx_irq", tx_irq, 0);
    chk("R8", "bus_oe", bus_oe, 0);
    chk("R8", "tx_overrun", tx_overrun, 0);

    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      v = VEC[i];
      case (v[25:24])
        2'd0: begin
          acc(v[23:22], v[21], v[20:13], rd);
          if (v[4]) chk($sformatf("R%0d", v[3:0]), $sformatf("vector %0d read", i),
                        rd, v[12:5]);
        end
        2'd1: rx_pulse(v[20:13]);
        default: done_pulse();
      endcase
    end
    // Two data reads with data present -> two acks; one send -> one request
    chk("R6", "ack count", ack_cnt, 2);
    chk("R7", "request count", req_cnt, 1);
    chk("R7", "tx_byte", tx_byte, 8'h3C);

    // R3 output enable during read, write and idle
    access(2'd2, 1'b1, 8'h00, 2'd2, 8'h00, rd, oe);
    chk("R3", "oe during read", oe, 1);
    access(2'd2, 1'b0, 8'h00, 2'd2, 8'h00, rd, oe);
    chk("R3", "oe during write", oe, 0);
    chk("R3", "oe idle", bus_oe, 0);
    chk("R3", "dout idle", bus_dout, 0);
    access(2'd1, 1'b1, 8'h00, 2'd1, 8'h00, rd, oe);
    chk("R9", "oe on invalid read", oe, 1);

    // R5 receive interrupt follows flag AND enable
    acc(2'd2, 1'b0, 8'h00, rd);
    rx_pulse(8'hC3);
    chk("R5", "rx_irq enable low", rx_irq, 0);
    acc(2'd2, 1'b0, 8'h02, rd);
    chk("R5", "rx_irq raised", rx_irq, 1);
    acc(2'd2, 1'b0, 8'h00, rd);
    chk("R5", "rx_irq dropped", rx_irq, 0);
    acc(2'd2, 1'b0, 8'h02, rd);
    chk("R5", "rx_irq re-raised", rx_irq, 1);

    // R1 select moved mid-access: status read, no data consumption
    a0 = ack_cnt;
    access(2'd2, 1'b1, 8'h00, 2'd0, 8'h00, rd, oe);
    chk("R1", "captured key read", rd, 8'h03);
    chk("R1", "no ack from moved select", ack_cnt, a0);
    chk("R1", "irq still high", rx_irq, 1);
    acc(2'd0, 1'b1, 8'h00, rd);
    chk("R6", "byte read", rd, 8'hC3);
    chk("R6", "rx_irq cleared by read", rx_irq, 0);
    chk("R6", "one ack", ack_cnt, a0 + 1);
    acc(2'd0, 1'b1, 8'h00, rd);
    chk("R6", "empty read gives no ack", ack_cnt, a0 + 1);

    // R5 transmit interrupt (enable already set, ready high)
    chk("R5", "tx_irq ready", tx_irq, 1);

    // R2 write data taken at chip-select rise
    r0 = req_cnt;
    access(2'd1, 1'b0, 8'h11, 2'd1, 8'h22, rd, oe);
    chk("R2", "tx_byte from late data", tx_byte, 8'h22);
    chk("R7", "request pulse", req_cnt, r0 + 1);
    chk("R5", "tx_irq dropped on write", tx_irq, 0);

    // R10 write while busy
    acc(2'd1, 1'b0, 8'h99, rd);
    chk("R10", "no extra request", req_cnt, r0 + 1);
    chk("R10", "tx_byte kept", tx_byte, 8'h22);
    chk("R10", "overrun set", tx_overrun, 1);
    done_pulse();
    chk("R5", "tx_irq after done", tx_irq, 1);
    chk("R10", "overrun sticky", tx_overrun, 1);

    // R8 reset again clears everything
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R8", "overrun after reset", tx_overrun, 0);
    chk("R8", "tx_irq after reset", tx_irq, 0);
    acc(2'd3, 1'b1, 8'h00, rd);
    chk("R8", "tx status after reset", rd, 8'h01);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule